// File: doc/BRIEF.md
# Priority Interrupt Arbiter

The block decides which interrupt, if any, is handed to the processor core. It watches eight active-low external request pins, a non-maskable request pin and two internal timer request strobes. Every source carries an 8-bit vector whose upper five bits give its priority. A maskable source is passed on only when its priority is strictly above the priority of the running process, which the core supplies on `run_prio`. The winner is presented to the core as `irq_req` with `irq_vec` and is held there until the core returns `irq_ack`.

The external port works in one of two ways. In per-pin mode (`port_vec_mode` low), each pin is its own source with its own vector, mask bit and trigger selection (falling edge or low level). In vector mode (`port_vec_mode` high), the port carries the inverted vector of a single external requester. That requester keeps the vector on the pins until the request is acknowledged. The non-maskable pin is triggered by a falling edge and beats every other source, whatever the masks and the process priority.

A three-state machine sequences the handshake. `ST_IDLE` waits for an eligible source and goes to `ST_POST` when the selector offers one, capturing the vector. `ST_POST` drives `irq_req` and goes to `ST_RETIRE` when `irq_ack` arrives. At that point it clears the pending bit of the granted source. `ST_RETIRE` lasts one cycle, so the cleared state settles before `ST_IDLE` arbitrates again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `irq_req` is low and `irq_vec` is 0.
- R2: In per-pin mode, a pin set to edge trigger (`pin_edge` bit = 1) becomes pending on a high-to-low transition. It posts its `pin_vec` entry once per transition, even if the pin stays low, and its pending bit is cleared by the acknowledge of that request.
- R3: In per-pin mode, a pin set to level trigger (`pin_edge` bit = 0) is pending for as long as it is held low. If it is still low after an acknowledge, it posts again.
- R4: A pin whose `pin_mask` bit is 1 is never posted. A falling edge seen while the pin is masked stays recorded and is posted once the mask bit returns to 0.
- R5: The priority of a vector is bits 7:3. A maskable source is posted only if that priority is strictly greater than `run_prio`. Vectors below 16 are never posted. A source held back by `run_prio` stays pending.
- R6: Among eligible maskable sources, the highest priority wins. On equal priority, the lower source index wins, in this order: pins 0 to 7, timer 0, timer 1, vector port.
- R7: In vector mode, the value posted is the bitwise inverse of the synchronized port, taken only when it is the same on two successive samples. An inverted value below 16 means no request. Pin masks and trigger settings have no effect, and edges seen in vector mode leave no pending pin after a return to per-pin mode.
- R8: A one-cycle high pulse on `tmr_req[j]` makes timer j pending with vector `tmr_vec[j]` until that request is acknowledged.
- R9: A falling edge on `nmi_n` posts vector `NMI_VEC` (default 248) ahead of every other source, regardless of masks and `run_prio`.
- R10: While `irq_req` is high and `irq_ack` is low, `irq_req` stays high and `irq_vec` stays unchanged, even if a higher request arrives. In the cycle after an acknowledge, `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_vec_mode | input | 1 | 1: the port carries an inverted vector; 0: per-pin sources |
| xint_n | input | 8 | External request port, active low, asynchronous |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered, asynchronous |
| tmr_req | input | 2 | Timer request strobes, synchronous pulses |
| pin_mask | input | 8 | Per-pin block bit (1 = blocked) |
| pin_edge | input | 8 | Per-pin trigger select (1 = falling edge, 0 = low level) |
| pin_vec | input | 8x8 | Vector of each external pin |
| tmr_vec | input | 2x8 | Vector of each timer |
| run_prio | input | 5 | Priority of the running process |
| irq_ack | input | 1 | Core accepts the posted request |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector of the posted request |

## Verification
Two things can fall in the same cycle. First, two sources can become pending at the same clock edge, which makes the selector rank them at once. Second, a new request can arrive while an earlier one is posted but not yet acknowledged. The bench provokes the first by pulsing two pins, two timers, or the non-maskable pin together with a pin in one cycle. It also holds sources back with a high `run_prio` and then releases them together. The order in which the vectors appear is judged against the ranking rules. For the second case, the bench delays the acknowledge and fires a higher-priority pin meanwhile. It checks that the posted vector does not change, and that the newcomer follows right after the gap cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_POST   = 2'd1,
        ST_RETIRE = 2'd2
    } pic_state_e;

endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                chain[k] <= {W{RST_VAL}};
            end
        end else begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) begin
                chain[k] <= chain[k-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pic_pend.sv
module pic_pend #(
    parameter int N_PIN = 8,
    parameter int N_TMR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ded_mode,
    input  logic [N_PIN-1:0] pin_s,
    input  logic [N_PIN-1:0] pin_edge,
    input  logic [N_TMR-1:0] tmr_req,
    input  logic             nmi_s,
    input  logic [N_PIN-1:0] clr_pin,
    input  logic [N_TMR-1:0] clr_tmr,
    input  logic             clr_nmi,
    output logic [N_PIN-1:0] pin_act,
    output logic [N_PIN-1:0] pin_prev,
    output logic [N_TMR-1:0] tmr_pend,
    output logic             nmi_pend
);

    logic [N_PIN-1:0] edge_pend;
    logic [N_PIN-1:0] fall;
    logic             nmi_prev;
    logic             nmi_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev <= '1;
            nmi_prev <= 1'b1;
        end else begin
            pin_prev <= pin_s;
            nmi_prev <= nmi_s;
        end
    end

    assign fall     = pin_prev & ~pin_s;
    assign nmi_fall = nmi_prev & ~nmi_s;

    generate
        for (genvar i = 0; i < N_PIN; i++) begin : g_pin
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    edge_pend[i] <= 1'b0;
                end else begin
                    edge_pend[i] <= ded_mode & pin_edge[i] &
                                    ((edge_pend[i] & ~clr_pin[i]) | fall[i]);
                end
            end

            assign pin_act[i] = pin_edge[i] ? edge_pend[i] : (ded_mode & ~pin_s[i]);

            a_r2_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
                (ded_mode && pin_edge[i] && fall[i]) |=> edge_pend[i]);
        end

        for (genvar j = 0; j < N_TMR; j++) begin : g_tmr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tmr_pend[j] <= 1'b0;
                end else begin
                    tmr_pend[j] <= (tmr_pend[j] & ~clr_tmr[j]) | tmr_req[j];
                end
            end

            a_r8_tmr_capture: assert property (@(posedge clk) disable iff (!rst_n)
                tmr_req[j] |=> tmr_pend[j]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pend <= 1'b0;
        end else begin
            nmi_pend <= (nmi_pend & ~clr_nmi) | nmi_fall;
        end
    end

    a_r9_nmi_capture: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_fall |=> nmi_pend);

endmodule

// File: rtl/pic_arb.sv
module pic_arb #(
    parameter int          N_PIN   = 8,
    parameter int          N_TMR   = 2,
    parameter int          VW      = 8,
    parameter int          PW      = 5,
    parameter int          VEC_MIN = 16,
    parameter logic [7:0]  NMI_VEC = 8'd248,
    localparam int         N_SRC   = N_PIN + N_TMR + 1,
    localparam int         SW      = $clog2(N_SRC + 1)
) (
    input  logic                        ded_mode,
    input  logic [N_PIN-1:0]            pin_act,
    input  logic [N_PIN-1:0]            pin_mask,
    input  logic [N_PIN-1:0][VW-1:0]    pin_vec,
    input  logic [N_TMR-1:0]            tmr_pend,
    input  logic [N_TMR-1:0][VW-1:0]    tmr_vec,
    input  logic [VW-1:0]               port_now,
    input  logic [VW-1:0]               port_prev,
    input  logic [PW-1:0]               proc_prio,
    input  logic                        nmi_pend,
    output logic                        sel_valid,
    output logic [VW-1:0]               sel_vec,
    output logic [SW-1:0]               sel_src,
    output logic                        sel_nmi
);

    localparam int PORT_IDX = N_SRC - 1;

    logic [N_SRC-1:0]          cand_ok;
    logic [N_SRC-1:0][VW-1:0]  cand_vec;
    logic [N_SRC-1:0]          elig;

    generate
        for (genvar i = 0; i < N_PIN; i++) begin : g_pin_cand
            assign cand_ok[i]  = ded_mode & pin_act[i] & ~pin_mask[i];
            assign cand_vec[i] = pin_vec[i];
        end
        for (genvar j = 0; j < N_TMR; j++) begin : g_tmr_cand
            assign cand_ok[N_PIN+j]  = tmr_pend[j];
            assign cand_vec[N_PIN+j] = tmr_vec[j];
        end
        for (genvar s = 0; s < N_SRC; s++) begin : g_elig
            assign elig[s] = cand_ok[s] &&
                             (int'(cand_vec[s]) >= VEC_MIN) &&
                             (cand_vec[s][VW-1 -: PW] > proc_prio);
        end
    endgenerate

    assign cand_ok[PORT_IDX]  = ~ded_mode & (port_now == port_prev);
    assign cand_vec[PORT_IDX] = port_now;

    always_comb begin
        logic [PW-1:0] best_prio;
        sel_valid = 1'b0;
        sel_vec   = '0;
        sel_src   = '0;
        sel_nmi   = 1'b0;
        best_prio = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (elig[s] && (!sel_valid || cand_vec[s][VW-1 -: PW] > best_prio)) begin
                sel_valid = 1'b1;
                sel_vec   = cand_vec[s];
                sel_src   = SW'(s);
                best_prio = cand_vec[s][VW-1 -: PW];
            end
        end
        if (nmi_pend) begin
            sel_valid = 1'b1;
            sel_vec   = VW'(NMI_VEC);
            sel_src   = SW'(N_SRC);
            sel_nmi   = 1'b1;
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int         N_PIN   = 8,
    parameter int         N_TMR   = 2,
    parameter int         VW      = 8,
    parameter int         PW      = 5,
    parameter int         SYNC    = 2,
    parameter int         VEC_MIN = 16,
    parameter logic [7:0] NMI_VEC = 8'd248
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      port_vec_mode,
    input  logic [N_PIN-1:0]          xint_n,
    input  logic                      nmi_n,
    input  logic [N_TMR-1:0]          tmr_req,
    input  logic [N_PIN-1:0]          pin_mask,
    input  logic [N_PIN-1:0]          pin_edge,
    input  logic [N_PIN-1:0][VW-1:0]  pin_vec,
    input  logic [N_TMR-1:0][VW-1:0]  tmr_vec,
    input  logic [PW-1:0]             run_prio,
    input  logic                      irq_ack,
    output logic                      irq_req,
    output logic [VW-1:0]             irq_vec
);

    localparam int N_SRC = N_PIN + N_TMR + 1;
    localparam int SW    = $clog2(N_SRC + 1);

    logic [N_PIN-1:0] pin_s;
    logic             nmi_s;
    logic [N_PIN-1:0] pin_act;
    logic [N_PIN-1:0] pin_prev;
    logic [N_TMR-1:0] tmr_pend;
    logic             nmi_pend;
    logic [N_PIN-1:0] clr_pin;
    logic [N_TMR-1:0] clr_tmr;
    logic             clr_nmi;
    logic             ded_mode;

    logic             sel_valid;
    logic [VW-1:0]    sel_vec;
    logic [SW-1:0]    sel_src;
    logic             sel_nmi;

    pic_state_e       state, state_nx;
    logic [SW-1:0]    held_src;
    logic             held_nmi;
    logic [VW-1:0]    held_vec;
    logic             retire;

    assign ded_mode = ~port_vec_mode;

    pic_sync #(.W(N_PIN), .STAGES(SYNC), .RST_VAL(1'b1)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (xint_n),
        .q     (pin_s)
    );

    pic_sync #(.W(1), .STAGES(SYNC), .RST_VAL(1'b1)) u_nmi_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nmi_n),
        .q     (nmi_s)
    );

    pic_pend #(.N_PIN(N_PIN), .N_TMR(N_TMR)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .ded_mode (ded_mode),
        .pin_s    (pin_s),
        .pin_edge (pin_edge),
        .tmr_req  (tmr_req),
        .nmi_s    (nmi_s),
        .clr_pin  (clr_pin),
        .clr_tmr  (clr_tmr),
        .clr_nmi  (clr_nmi),
        .pin_act  (pin_act),
        .pin_prev (pin_prev),
        .tmr_pend (tmr_pend),
        .nmi_pend (nmi_pend)
    );

    pic_arb #(
        .N_PIN   (N_PIN),
        .N_TMR   (N_TMR),
        .VW      (VW),
        .PW      (PW),
        .VEC_MIN (VEC_MIN),
        .NMI_VEC (NMI_VEC)
    ) u_arb (
        .ded_mode  (ded_mode),
        .pin_act   (pin_act),
        .pin_mask  (pin_mask),
        .pin_vec   (pin_vec),
        .tmr_pend  (tmr_pend),
        .tmr_vec   (tmr_vec),
        .port_now  (~pin_s),
        .port_prev (~pin_prev),
        .proc_prio (run_prio),
        .nmi_pend  (nmi_pend),
        .sel_valid (sel_valid),
        .sel_vec   (sel_vec),
        .sel_src   (sel_src),
        .sel_nmi   (sel_nmi)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (sel_valid) state_nx = ST_POST;
            ST_POST:   if (irq_ack)   state_nx = ST_RETIRE;
            ST_RETIRE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Grant capture on the IDLE to POST transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_vec <= '0;
            held_src <= '0;
            held_nmi <= 1'b0;
        end else if (state == ST_IDLE && sel_valid) begin
            held_vec <= sel_vec;
            held_src <= sel_src;
            held_nmi <= sel_nmi;
        end
    end

    // Outputs and pending clears
    always_comb begin
        irq_req = 1'b0;
        retire  = 1'b0;
        unique case (state)
            ST_IDLE:   irq_req = 1'b0;
            ST_POST: begin
                irq_req = 1'b1;
                retire  = irq_ack;
            end
            ST_RETIRE: irq_req = 1'b0;
            default:   irq_req = 1'b0;
        endcase
        for (int i = 0; i < N_PIN; i++) begin
            clr_pin[i] = retire && !held_nmi && (held_src == SW'(i));
        end
        for (int j = 0; j < N_TMR; j++) begin
            clr_tmr[j] = retire && !held_nmi && (held_src == SW'(N_PIN + j));
        end
        clr_nmi = retire && held_nmi;
    end

    assign irq_vec = held_vec;

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    a_r5_vec_floor: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_vec) >= VEC_MIN));

    a_r5_above_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req) && irq_vec != VW'(NMI_VEC)) |->
            (irq_vec[VW-1 -: PW] > $past(run_prio)));

    a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && nmi_pend) |=> (irq_req && irq_vec == VW'(NMI_VEC)));

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    logic            clk;
    logic            rst_n;
    logic            port_vec_mode;
    logic [7:0]      xint_n;
    logic            nmi_n;
    logic [1:0]      tmr_req;
    logic [7:0]      pin_mask;
    logic [7:0]      pin_edge;
    logic [7:0][7:0] pin_vec;
    logic [1:0][7:0] tmr_vec;
    logic [4:0]      run_prio;
    logic            irq_ack;
    logic            irq_req;
    logic [7:0]      irq_vec;

    int   total = 0;
    int   bad   = 0;
    int   seen  = 0;
    int   ack_delay = 0;
    bit   rel_on_last = 0;
    bit   done = 0;
    string cur_tag = "R2";
    logic [7:0] exp_q[$];

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_vec_mode (port_vec_mode),
        .xint_n        (xint_n),
        .nmi_n         (nmi_n),
        .tmr_req       (tmr_req),
        .pin_mask      (pin_mask),
        .pin_edge      (pin_edge),
        .pin_vec       (pin_vec),
        .tmr_vec       (tmr_vec),
        .run_prio      (run_prio),
        .irq_ack       (irq_ack),
        .irq_req       (irq_req),
        .irq_vec       (irq_vec)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet(input int n, input string tag);
        bit clean = 1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (irq_req) clean = 0;
        end
        chk(clean, tag, 1, 0);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    task automatic pulse_pins(input logic [7:0] m);
        @(negedge clk);
        xint_n = xint_n & ~m;
        repeat (2) @(negedge clk);
        xint_n = xint_n | m;
    endtask

    // Monitor: compares each posted vector against the expectation queue
    initial begin
        irq_ack = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (irq_ack) begin
                    irq_ack = 1'b0;
                    chk(!irq_req, "R10 gap after ack", int'(irq_req), 0);
                end else if (irq_req) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "unexpected request", int'(irq_vec), 0);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        chk(irq_vec == e, cur_tag, int'(irq_vec), int'(e));
                        seen++;
                        if (rel_on_last && exp_q.size() == 0) begin
                            xint_n      = 8'hFF;
                            rel_on_last = 0;
                        end
                        for (int d = 0; d < ack_delay; d++) begin
                            @(negedge clk);
                            chk(irq_req && irq_vec == e, "R10 hold until ack",
                                int'(irq_vec), int'(e));
                        end
                    end
                    irq_ack = 1'b1;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver
    initial begin
        rst_n = 1'b0;
        port_vec_mode = 1'b0;
        xint_n = 8'hFF;
        nmi_n = 1'b1;
        tmr_req = 2'b00;
        pin_mask = 8'h00;
        pin_edge = 8'hFF;
        for (int i = 0; i < 8; i++) pin_vec[i] = 8'(8'h20 + 8 * i);
        tmr_vec[0] = 8'h88;
        tmr_vec[1] = 8'h89;
        run_prio = 5'd0;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!irq_req, "R1 req after reset", int'(irq_req), 0);
        chk(irq_vec == 8'h00, "R1 vec after reset", int'(irq_vec), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!irq_req, "R1 idle after release", int'(irq_req), 0);

        // R2: single falling edge
        cur_tag = "R2 edge pin";
        pin_vec[3] = 8'h58;
        exp_q.push_back(8'h58);
        pulse_pins(8'h08);
        drain();
        // R2: pin held low posts only once
        pin_vec[5] = 8'h68;
        exp_q.push_back(8'h68);
        xint_n[5] = 1'b0;
        drain();
        quiet(10, "R2 one post per edge");
        xint_n[5] = 1'b1;
        repeat (5) @(negedge clk);

        // R3: level pin reposts while low
        cur_tag = "R3 level pin";
        pin_edge[2] = 1'b0;
        pin_vec[2] = 8'h70;
        exp_q.push_back(8'h70);
        exp_q.push_back(8'h70);
        rel_on_last = 1;
        xint_n[2] = 1'b0;
        drain();
        quiet(10, "R3 stops after release");
        pin_edge[2] = 1'b1;

        // R4: mask blocks, edge kept
        cur_tag = "R4 unmasked post";
        pin_mask[1] = 1'b1;
        pin_vec[1] = 8'h30;
        pulse_pins(8'h02);
        quiet(12, "R4 masked pin silent");
        exp_q.push_back(8'h30);
        pin_mask[1] = 1'b0;
        drain();

        // R5: priority against run_prio
        cur_tag = "R5 above run prio";
        run_prio = 5'd10;
        pin_vec[4] = 8'h50;
        pulse_pins(8'h10);
        quiet(12, "R5 equal prio held");
        exp_q.push_back(8'h50);
        run_prio = 5'd9;
        drain();
        run_prio = 5'd10;
        pin_vec[4] = 8'h58;
        exp_q.push_back(8'h58);
        pulse_pins(8'h10);
        drain();
        run_prio = 5'd0;
        pin_vec[7] = 8'h0C;
        pulse_pins(8'h80);
        quiet(12, "R5 vector below 16");
        pin_edge[7] = 1'b0;
        repeat (3) @(negedge clk);
        pin_edge[7] = 1'b1;
        quiet(6, "R5 low vector dropped");

        // R6: simultaneous pins, priority and tie
        cur_tag = "R6 ranking";
        pin_vec[0] = 8'h40;
        pin_vec[6] = 8'h90;
        exp_q.push_back(8'h90);
        exp_q.push_back(8'h40);
        pulse_pins(8'h41);
        drain();
        cur_tag = "R6 tie lower index";
        pin_vec[2] = 8'h60;
        pin_vec[5] = 8'h67;
        exp_q.push_back(8'h60);
        exp_q.push_back(8'h67);
        pulse_pins(8'h24);
        drain();

        // R8: timers, tie between them
        cur_tag = "R8 timers";
        exp_q.push_back(8'h88);
        exp_q.push_back(8'h89);
        @(negedge clk);
        tmr_req = 2'b11;
        @(negedge clk);
        tmr_req = 2'b00;
        drain();
        // R6: pin vs timer released together
        cur_tag = "R6 pin over timer";
        run_prio = 5'd31;
        pin_vec[1] = 8'hA0;
        pulse_pins(8'h02);
        @(negedge clk);
        tmr_req = 2'b01;
        @(negedge clk);
        tmr_req = 2'b00;
        repeat (6) @(negedge clk);
        exp_q.push_back(8'hA0);
        exp_q.push_back(8'h88);
        run_prio = 5'd0;
        drain();
        cur_tag = "R6 pin ties timer";
        run_prio = 5'd31;
        pin_vec[1] = 8'h8C;
        pulse_pins(8'h02);
        @(negedge clk);
        tmr_req = 2'b01;
        @(negedge clk);
        tmr_req = 2'b00;
        repeat (6) @(negedge clk);
        exp_q.push_back(8'h8C);
        exp_q.push_back(8'h88);
        run_prio = 5'd0;
        drain();

        // R9: NMI ignores run_prio and wins
        cur_tag = "R9 nmi first";
        run_prio = 5'd31;
        exp_q.push_back(8'hF8);
        @(negedge clk);
        nmi_n = 1'b0;
        xint_n[0] = 1'b0;
        repeat (2) @(negedge clk);
        nmi_n = 1'b1;
        xint_n[0] = 1'b1;
        drain();
        cur_tag = "R9 pin after nmi";
        exp_q.push_back(8'h40);
        run_prio = 5'd0;
        drain();

        // R7: vector mode
        cur_tag = "R7 port vector";
        port_vec_mode = 1'b1;
        repeat (4) @(negedge clk);
        exp_q.push_back(8'hA5);
        rel_on_last = 1;
        xint_n = ~8'hA5;
        drain();
        xint_n = ~8'h0F;
        quiet(12, "R7 port below 16");
        xint_n = 8'hFF;
        repeat (4) @(negedge clk);
        run_prio = 5'd20;
        xint_n = ~8'hA0;
        quiet(12, "R7 R5 port at run prio");
        xint_n = 8'hFF;
        repeat (4) @(negedge clk);
        cur_tag = "R7 port above run prio";
        exp_q.push_back(8'hA8);
        rel_on_last = 1;
        xint_n = ~8'hA8;
        drain();
        run_prio = 5'd0;
        port_vec_mode = 1'b0;
        quiet(12, "R7 no pin pending after mode change");

        // R10: hold until ack while a higher request arrives
        cur_tag = "R10 locked post";
        ack_delay = 5;
        pin_vec[1] = 8'h30;
        pin_vec[6] = 8'h90;
        exp_q.push_back(8'h30);
        exp_q.push_back(8'h90);
        begin
            int base;
            base = seen;
            pulse_pins(8'h02);
            while (seen == base) @(negedge clk);
        end
        pulse_pins(8'h40);
        drain();
        ack_delay = 0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule